// File: doc/BRIEF.md
# Trap Entry and Debug Redirect Unit

This unit computes the architectural side effects of taking an exception or interrupt in a processor with the privilege levels U, S, H and M. A trap is presented for one cycle on `trap_valid_i`, together with its cause, the faulting PC, an optional bad address and the current privilege and status word. On the next clock edge the unit commits every update together. These updates are the new PC, the new privilege, the restacked status word, and write strobes with data for the cause, exception-PC and bad-address registers of the chosen handler level. Where the trap is a breakpoint that should halt the core, the unit instead issues the debug-control and debug-PC writes.

There are four destinations. A trap taken while a debug cause is already recorded only redirects to the debug exception address. A breakpoint whose per-privilege halt enable is set enters debug mode. Any other trap goes to the supervisor handler when delegated, and to the machine handler otherwise. Choosing which interrupt to raise, and fetching or decoding instructions, happen elsewhere. The PC and privilege outputs keep their values between traps. A separate pulse reports a privilege change so that an address-translation cache can be flushed.

Top module: `trap_entry`

## Requirements
- R1: After reset `pc_o` is RESET_PC, `priv_o` is M (3), `status_o` is 0, and every strobe (`redirect_o`, `s_we_o`, `m_we_o`, `dbg_we_o`, `bad_we_o`, `resv_clr_o`, `priv_flush_o`) is 0.
- R2: In a cycle without `trap_valid_i`, the next edge leaves `pc_o`, `priv_o` and `status_o` unchanged and drives every strobe to 0. All outputs are registered, so a trap sampled at edge N is visible after edge N.
- R3: A trap whose cause is the breakpoint code 3 (top bit clear), taken while `ebreak_en_i[priv_i]` is 1 and `dbg_cause_i` is 0, enters debug. The results are `pc_o` = DBG_ROM_ADDR, `priv_o` = M, `dbg_we_o` = 1, `dcsr_cause_o` = 1 (software breakpoint), `dcsr_prv_o` = `priv_i`, `epc_o` = `epc_i` (the debug PC), and `status_o` = `status_i`. `resv_clr_o` stays 0.
- R4: A breakpoint taken while the enable bit for the current privilege is 0 is handled as an ordinary exception (R8/R9), even when the enables for other levels are set.
- R5: With `dbg_cause_i` nonzero, any trap sets `pc_o` = DBG_EXC_ADDR and keeps `priv_o` = `priv_i` and `status_o` = `status_i`. `redirect_o` is the only strobe raised.
- R6: An interrupt (cause bit XLEN-1 set) is looked up in `mideleg_i` at the index given by the remaining cause bits. An exception is looked up in `medeleg_i`.
- R7: A trap goes to supervisor only when `priv_i` <= S (1), the cause index is below XLEN and the selected delegation bit is 1. Otherwise it goes to machine.
- R8: The supervisor path gives `pc_o` = `stvec_i`, `priv_o` = S, `s_we_o` = 1, `cause_o` = `cause_i`, `epc_o` = `epc_i`, and `bad_we_o` = `badaddr_valid_i` with `badaddr_o` = `badaddr_i`. In the status word, bit 5 takes `status_i[priv_i]`, bit 8 takes `priv_i[0]`, bit 1 is cleared, and all other bits are kept.
- R9: The machine path gives `pc_o` = `mtvec_i`, `priv_o` = M and `m_we_o` = 1, with the same cause, EPC and bad-address data as R8. In the status word, bit 7 takes `status_i[priv_i]`, bits 12:11 take `priv_i`, bit 3 is cleared, and all other bits are kept.
- R10: `resv_clr_o` pulses exactly on the supervisor and machine paths.
- R11: `priv_flush_o` pulses with `redirect_o` exactly when the committed privilege differs from `priv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid_i | input | 1 | One-cycle trap strobe |
| cause_i | input | XLEN | Trap cause; top bit marks an interrupt |
| epc_i | input | XLEN | PC of the trapping instruction |
| badaddr_valid_i | input | 1 | A bad address accompanies the trap |
| badaddr_i | input | XLEN | Faulting address |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 2 H, 3 M) |
| status_i | input | 13 | Current status word |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor handler address |
| mtvec_i | input | XLEN | Machine handler address |
| ebreak_en_i | input | 4 | Breakpoint-halts enable, indexed by privilege |
| dbg_cause_i | input | 3 | Recorded debug cause; nonzero while in debug |
| redirect_o | output | 1 | Pulse: a trap was committed |
| pc_o | output | XLEN | Next PC, held between traps |
| priv_o | output | 2 | Next privilege, held between traps |
| status_o | output | 13 | Updated status word |
| s_we_o | output | 1 | Write supervisor cause/EPC |
| m_we_o | output | 1 | Write machine cause/EPC |
| cause_o | output | XLEN | Cause write data |
| epc_o | output | XLEN | EPC (or debug PC) write data |
| bad_we_o | output | 1 | Write the bad-address register of the chosen level |
| badaddr_o | output | XLEN | Bad-address write data |
| dbg_we_o | output | 1 | Write debug-control fields and debug PC |
| dcsr_cause_o | output | 3 | Debug cause write data |
| dcsr_prv_o | output | 2 | Privilege recorded on debug entry |
| resv_clr_o | output | 1 | Pulse: drop the load reservation |
| priv_flush_o | output | 1 | Pulse: privilege changed |

## Verification
Several properties are checked on every cycle: the PC and privilege hold between traps, at most one destination strobe fires, each destination leaves the right privilege and a cleared enable bit, a debug entry never drops the reservation, the flush pulse only appears with a redirect, and machine-level traps are never delegated. The bench scenarios are needed for the parts that depend on values. These are the delegation lookup in the correct mask, the out-of-range cause index, the breakpoint enable for each privilege, the exact stacked status bits, and the data on the cause, EPC and bad-address writes.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int STAT_W = 13;

    // status word bit positions; the enable of level p sits at bit p
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPP  = 11;

    localparam logic [1:0] LVL_U = 2'd0;
    localparam logic [1:0] LVL_S = 2'd1;
    localparam logic [1:0] LVL_H = 2'd2;
    localparam logic [1:0] LVL_M = 2'd3;

    localparam logic [2:0] DCAUSE_SWBP = 3'd1;

    typedef enum logic [1:0] {
        DEST_SUP       = 2'd0,
        DEST_MACH      = 2'd1,
        DEST_DBG_ENTER = 2'd2,
        DEST_DBG_EXC   = 2'd3
    } dest_e;

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int BRK_CODE = 3
) (
    input  logic [XLEN-1:0] cause,
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] edeleg,
    input  logic [XLEN-1:0] ideleg,
    input  logic [3:0]      brk_halt_en,
    input  logic [2:0]      dbg_cause,
    output dest_e           dest
);
    localparam int IDXW = $clog2(XLEN);

    logic            is_irq;
    logic [XLEN-1:0] idx;
    logic            idx_ok;
    logic [XLEN-1:0] mask_sel;
    logic            deleg_bit;
    logic            is_brk;

    always_comb begin
        is_irq    = cause[XLEN-1];
        idx       = {1'b0, cause[XLEN-2:0]};
        idx_ok    = idx < XLEN;
        mask_sel  = is_irq ? ideleg : edeleg;
        deleg_bit = idx_ok && mask_sel[idx[IDXW-1:0]];
        is_brk    = !is_irq && (cause == XLEN'(BRK_CODE));

        if (dbg_cause != 3'd0)
            dest = DEST_DBG_EXC;
        else if (is_brk && brk_halt_en[priv])
            dest = DEST_DBG_ENTER;
        else if (priv <= LVL_S && deleg_bit)
            dest = DEST_SUP;
        else
            dest = DEST_MACH;
    end
endmodule

// File: rtl/status_stack.sv
module status_stack
    import trap_pkg::*;
(
    input  logic [STAT_W-1:0] stat_in,
    input  logic [1:0]        priv,
    input  logic              to_sup,
    output logic [STAT_W-1:0] stat_out
);
    logic prev_ie;

    always_comb begin
        prev_ie  = stat_in[priv];
        stat_out = stat_in;
        if (to_sup) begin
            stat_out[ST_SPIE] = prev_ie;
            stat_out[ST_SPP]  = priv[0];
            stat_out[ST_SIE]  = 1'b0;
        end else begin
            stat_out[ST_MPIE]          = prev_ie;
            stat_out[ST_MPP+1:ST_MPP]  = priv;
            stat_out[ST_MIE]           = 1'b0;
        end
    end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
    import trap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              BRK_CODE     = 3,
    parameter logic [XLEN-1:0] RESET_PC     = 32'h0001_0000,
    parameter logic [XLEN-1:0] DBG_ROM_ADDR = 32'h0000_0800,
    parameter logic [XLEN-1:0] DBG_EXC_ADDR = 32'h0000_0808
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid_i,
    input  logic [XLEN-1:0]   cause_i,
    input  logic [XLEN-1:0]   epc_i,
    input  logic              badaddr_valid_i,
    input  logic [XLEN-1:0]   badaddr_i,
    input  logic [1:0]        priv_i,
    input  logic [12:0]       status_i,
    input  logic [XLEN-1:0]   medeleg_i,
    input  logic [XLEN-1:0]   mideleg_i,
    input  logic [XLEN-1:0]   stvec_i,
    input  logic [XLEN-1:0]   mtvec_i,
    input  logic [3:0]        ebreak_en_i,
    input  logic [2:0]        dbg_cause_i,
    output logic              redirect_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [1:0]        priv_o,
    output logic [12:0]       status_o,
    output logic              s_we_o,
    output logic              m_we_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              bad_we_o,
    output logic [XLEN-1:0]   badaddr_o,
    output logic              dbg_we_o,
    output logic [2:0]        dcsr_cause_o,
    output logic [1:0]        dcsr_prv_o,
    output logic              resv_clr_o,
    output logic              priv_flush_o
);
    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [1:0]        priv;
        logic [STAT_W-1:0] status;
        logic              redirect;
        logic              s_we;
        logic              m_we;
        logic              bad_we;
        logic              dbg_we;
        logic              resv_clr;
        logic              priv_flush;
        logic [XLEN-1:0]   cause;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   badaddr;
        logic [2:0]        dcsr_cause;
        logic [1:0]        dcsr_prv;
    } te_state_t;

    te_state_t         st_d, st_q;
    dest_e             dest;
    logic [STAT_W-1:0] stacked;

    trap_route #(.XLEN(XLEN), .BRK_CODE(BRK_CODE)) u_route (
        .cause       (cause_i),
        .priv        (priv_i),
        .edeleg      (medeleg_i),
        .ideleg      (mideleg_i),
        .brk_halt_en (ebreak_en_i),
        .dbg_cause   (dbg_cause_i),
        .dest        (dest)
    );

    status_stack u_stack (
        .stat_in  (status_i),
        .priv     (priv_i),
        .to_sup   (dest == DEST_SUP),
        .stat_out (stacked)
    );

    always_comb begin
        st_d            = st_q;
        st_d.redirect   = 1'b0;
        st_d.s_we       = 1'b0;
        st_d.m_we       = 1'b0;
        st_d.bad_we     = 1'b0;
        st_d.dbg_we     = 1'b0;
        st_d.resv_clr   = 1'b0;
        st_d.priv_flush = 1'b0;
        if (trap_valid_i) begin
            st_d.redirect = 1'b1;
            unique case (dest)
                DEST_DBG_EXC: begin
                    st_d.pc     = DBG_EXC_ADDR;
                    st_d.priv   = priv_i;
                    st_d.status = status_i;
                end
                DEST_DBG_ENTER: begin
                    st_d.pc         = DBG_ROM_ADDR;
                    st_d.priv       = LVL_M;
                    st_d.status     = status_i;
                    st_d.dbg_we     = 1'b1;
                    st_d.dcsr_cause = DCAUSE_SWBP;
                    st_d.dcsr_prv   = priv_i;
                    st_d.epc        = epc_i;
                end
                DEST_SUP, DEST_MACH: begin
                    st_d.pc       = (dest == DEST_SUP) ? stvec_i : mtvec_i;
                    st_d.priv     = (dest == DEST_SUP) ? LVL_S : LVL_M;
                    st_d.s_we     = (dest == DEST_SUP);
                    st_d.m_we     = (dest == DEST_MACH);
                    st_d.status   = stacked;
                    st_d.cause    = cause_i;
                    st_d.epc      = epc_i;
                    st_d.bad_we   = badaddr_valid_i;
                    st_d.resv_clr = 1'b1;
                    if (badaddr_valid_i)
                        st_d.badaddr = badaddr_i;
                end
                default: ;
            endcase
            st_d.priv_flush = (st_d.priv != priv_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pc   <= RESET_PC;
            st_q.priv <= LVL_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o   = st_q.redirect;
    assign pc_o         = st_q.pc;
    assign priv_o       = st_q.priv;
    assign status_o     = st_q.status;
    assign s_we_o       = st_q.s_we;
    assign m_we_o       = st_q.m_we;
    assign cause_o      = st_q.cause;
    assign epc_o        = st_q.epc;
    assign bad_we_o     = st_q.bad_we;
    assign badaddr_o    = st_q.badaddr;
    assign dbg_we_o     = st_q.dbg_we;
    assign dcsr_cause_o = st_q.dcsr_cause;
    assign dcsr_prv_o   = st_q.dcsr_prv;
    assign resv_clr_o   = st_q.resv_clr;
    assign priv_flush_o = st_q.priv_flush;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] DBG_EXC_ADDR = 32'h0000_0808
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid_i,
    input logic [1:0]      priv_i,
    input logic [2:0]      dbg_cause_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] pc_o,
    input logic [1:0]      priv_o,
    input logic [12:0]     status_o,
    input logic            s_we_o,
    input logic            m_we_o,
    input logic            dbg_we_o,
    input logic [2:0]      dcsr_cause_o,
    input logic            resv_clr_o,
    input logic            priv_flush_o
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> $stable(pc_o) && $stable(priv_o) && !redirect_o);

    p_one_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_we_o, m_we_o, dbg_we_o}));

    p_sup_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_we_o |-> priv_o == 2'd1 && !status_o[1]);

    p_mach_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_we_o |-> priv_o == 2'd3 && !status_o[3]);

    p_dbg_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_we_o |-> priv_o == 2'd3 && !resv_clr_o && dcsr_cause_o == 3'd1);

    p_dbg_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i && dbg_cause_i != 3'd0 |=>
            redirect_o && !s_we_o && !m_we_o && !dbg_we_o && pc_o == DBG_EXC_ADDR);

    p_resv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clr_o == (s_we_o || m_we_o));

    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        priv_flush_o |-> redirect_o);

    p_no_mdeleg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i && priv_i == 2'd3 |=> !s_we_o);
endmodule

bind trap_entry trap_entry_chk #(.XLEN(XLEN), .DBG_EXC_ADDR(DBG_EXC_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_valid_i (trap_valid_i),
    .priv_i       (priv_i),
    .dbg_cause_i  (dbg_cause_i),
    .redirect_o   (redirect_o),
    .pc_o         (pc_o),
    .priv_o       (priv_o),
    .status_o     (status_o),
    .s_we_o       (s_we_o),
    .m_we_o       (m_we_o),
    .dbg_we_o     (dbg_we_o),
    .dcsr_cause_o (dcsr_cause_o),
    .resv_clr_o   (resv_clr_o),
    .priv_flush_o (priv_flush_o)
);

// File: tb/trap_entry_tb.sv
module trap_entry_tb;
    localparam int XLEN = 32;
    localparam logic [31:0] RST_PC  = 32'h0001_0000;
    localparam logic [31:0] DBG_ROM = 32'h0000_0800;
    localparam logic [31:0] DBG_EXC = 32'h0000_0808;
    localparam logic [31:0] STVEC   = 32'h0000_0100;
    localparam logic [31:0] MTVEC   = 32'h0000_0200;

    // expected destination codes: 0 supervisor, 1 machine, 2 debug entry, 3 debug exception
    typedef struct packed {
        logic [1:0]  priv;
        logic [12:0] status;
        logic [31:0] cause;
        logic        hasbad;
        logic [3:0]  ebk;
        logic [2:0]  dcause;
        logic [31:0] edeleg;
        logic [31:0] ideleg;
        logic [31:0] x_pc;
        logic [1:0]  x_priv;
        logic [12:0] x_status;
        logic [1:0]  x_dest;
        logic        x_flush;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R8 R6: U exception delegated
        '{2'd0, 13'h001, 32'd2, 1'b1, 4'b0000, 3'd0, 32'h4, 32'h0, STVEC, 2'd1, 13'h021, 2'd0, 1'b1},
        // R9 R7: U exception not delegated
        '{2'd0, 13'h001, 32'd2, 1'b1, 4'b0000, 3'd0, 32'h0, 32'h0, MTVEC, 2'd3, 13'h081, 2'd1, 1'b1},
        // R8: S exception delegated, SPP=1
        '{2'd1, 13'h002, 32'd8, 1'b0, 4'b0000, 3'd0, 32'h100, 32'h0, STVEC, 2'd1, 13'h120, 2'd0, 1'b0},
        // R7: M never delegates
        '{2'd3, 13'h008, 32'd8, 1'b0, 4'b0000, 3'd0, 32'hFFFF_FFFF, 32'h0, MTVEC, 2'd3, 13'h1880, 2'd1, 1'b0},
        // R6: interrupt uses ideleg
        '{2'd1, 13'h000, 32'h8000_0005, 1'b0, 4'b0000, 3'd0, 32'h0, 32'h20, STVEC, 2'd1, 13'h100, 2'd0, 1'b0},
        // R6: interrupt ignores edeleg
        '{2'd1, 13'h002, 32'h8000_0005, 1'b0, 4'b0000, 3'd0, 32'h20, 32'h0, MTVEC, 2'd3, 13'h882, 2'd1, 1'b1},
        // R7: cause index out of range
        '{2'd0, 13'h000, 32'd40, 1'b0, 4'b0000, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, MTVEC, 2'd3, 13'h000, 2'd1, 1'b1},
        // R3: breakpoint in U with U enable
        '{2'd0, 13'h001, 32'd3, 1'b0, 4'b0001, 3'd0, 32'h0, 32'h0, DBG_ROM, 2'd3, 13'h001, 2'd2, 1'b1},
        // R4: breakpoint in S, only U enabled
        '{2'd1, 13'h002, 32'd3, 1'b0, 4'b0001, 3'd0, 32'h8, 32'h0, STVEC, 2'd1, 13'h120, 2'd0, 1'b0},
        // R3: breakpoint in M
        '{2'd3, 13'h008, 32'd3, 1'b0, 4'b1000, 3'd0, 32'h0, 32'h0, DBG_ROM, 2'd3, 13'h008, 2'd2, 1'b0},
        // R5: already in debug
        '{2'd1, 13'h002, 32'd2, 1'b1, 4'b1111, 3'd1, 32'h4, 32'h0, DBG_EXC, 2'd1, 13'h002, 2'd3, 1'b0},
        // R3: breakpoint in H
        '{2'd2, 13'h004, 32'd3, 1'b0, 4'b0100, 3'd0, 32'h0, 32'h0, DBG_ROM, 2'd3, 13'h004, 2'd2, 1'b1},
        // R7 R9: H above S, not delegated
        '{2'd2, 13'h004, 32'd2, 1'b0, 4'b0000, 3'd0, 32'h4, 32'h0, MTVEC, 2'd3, 13'h1084, 2'd1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_valid_i = 1'b0;
    logic [31:0] cause_i = '0, epc_i = '0, badaddr_i = '0;
    logic badaddr_valid_i = 1'b0;
    logic [1:0] priv_i = '0;
    logic [12:0] status_i = '0;
    logic [31:0] medeleg_i = '0, mideleg_i = '0;
    logic [31:0] stvec_i = STVEC, mtvec_i = MTVEC;
    logic [3:0] ebreak_en_i = '0;
    logic [2:0] dbg_cause_i = '0;
    logic redirect_o, s_we_o, m_we_o, bad_we_o, dbg_we_o, resv_clr_o, priv_flush_o;
    logic [31:0] pc_o, cause_o, epc_o, badaddr_o;
    logic [1:0] priv_o, dcsr_prv_o;
    logic [12:0] status_o;
    logic [2:0] dcsr_cause_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trap_entry #(.XLEN(XLEN), .RESET_PC(RST_PC), .DBG_ROM_ADDR(DBG_ROM),
                 .DBG_EXC_ADDR(DBG_EXC)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid_i), .cause_i(cause_i),
        .epc_i(epc_i), .badaddr_valid_i(badaddr_valid_i), .badaddr_i(badaddr_i),
        .priv_i(priv_i), .status_i(status_i), .medeleg_i(medeleg_i),
        .mideleg_i(mideleg_i), .stvec_i(stvec_i), .mtvec_i(mtvec_i),
        .ebreak_en_i(ebreak_en_i), .dbg_cause_i(dbg_cause_i),
        .redirect_o(redirect_o), .pc_o(pc_o), .priv_o(priv_o), .status_o(status_o),
        .s_we_o(s_we_o), .m_we_o(m_we_o), .cause_o(cause_o), .epc_o(epc_o),
        .bad_we_o(bad_we_o), .badaddr_o(badaddr_o), .dbg_we_o(dbg_we_o),
        .dcsr_cause_o(dcsr_cause_o), .dcsr_prv_o(dcsr_prv_o),
        .resv_clr_o(resv_clr_o), .priv_flush_o(priv_flush_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic string dtag(input logic [1:0] d);
        case (d)
            2'd0: return "R8";
            2'd1: return "R9";
            2'd2: return "R3";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc_o, RST_PC);
        chk("R1 priv", 32'(priv_o), 32'd3);
        chk("R1 status", 32'(status_o), 32'd0);
        chk("R1 strobes", 32'({redirect_o, s_we_o, m_we_o, bad_we_o, dbg_we_o, resv_clr_o, priv_flush_o}), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            priv_i          = VECS[i].priv;
            status_i        = VECS[i].status;
            cause_i         = VECS[i].cause;
            badaddr_valid_i = VECS[i].hasbad;
            badaddr_i       = 32'hBAD0_0000 + 32'(i);
            epc_i           = 32'h4000 + 32'(4 * i);
            ebreak_en_i     = VECS[i].ebk;
            dbg_cause_i     = VECS[i].dcause;
            medeleg_i       = VECS[i].edeleg;
            mideleg_i       = VECS[i].ideleg;
            trap_valid_i    = 1'b1;
            @(negedge clk);
            trap_valid_i = 1'b0;
            chk({dtag(VECS[i].x_dest), " pc"}, pc_o, VECS[i].x_pc);
            chk({dtag(VECS[i].x_dest), " priv"}, 32'(priv_o), 32'(VECS[i].x_priv));
            chk({dtag(VECS[i].x_dest), " status"}, 32'(status_o), 32'(VECS[i].x_status));
            chk({dtag(VECS[i].x_dest), " dest strobes"}, 32'({redirect_o, s_we_o, m_we_o, dbg_we_o}),
                32'({1'b1, VECS[i].x_dest == 2'd0, VECS[i].x_dest == 2'd1, VECS[i].x_dest == 2'd2}));
            chk("R11 flush", 32'(priv_flush_o), 32'(VECS[i].x_flush));
            chk("R10 resv", 32'(resv_clr_o), 32'(VECS[i].x_dest < 2'd2));
            if (VECS[i].x_dest < 2'd2) begin
                chk({dtag(VECS[i].x_dest), " cause"}, cause_o, VECS[i].cause);
                chk({dtag(VECS[i].x_dest), " epc"}, epc_o, 32'h4000 + 32'(4 * i));
                chk({dtag(VECS[i].x_dest), " bad_we"}, 32'(bad_we_o), 32'(VECS[i].hasbad));
                if (VECS[i].hasbad)
                    chk({dtag(VECS[i].x_dest), " badaddr"}, badaddr_o, 32'hBAD0_0000 + 32'(i));
            end else if (VECS[i].x_dest == 2'd2) begin
                chk("R3 dcsr cause", 32'(dcsr_cause_o), 32'd1);
                chk("R3 dcsr prv", 32'(dcsr_prv_o), 32'(VECS[i].priv));
                chk("R3 dpc", epc_o, 32'h4000 + 32'(4 * i));
                chk("R3 bad_we", 32'(bad_we_o), 32'd0);
            end else begin
                chk("R5 bad_we", 32'(bad_we_o), 32'd0);
            end
        end

        // R2: inputs change without a trap; outputs hold, strobes drop
        @(negedge clk);
        priv_i = 2'd0;
        status_i = 13'h1FFF;
        cause_i = 32'd2;
        medeleg_i = 32'hFFFF_FFFF;
        dbg_cause_i = 3'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 pc hold", pc_o, MTVEC);
        chk("R2 priv hold", 32'(priv_o), 32'd3);
        chk("R2 status hold", 32'(status_o), 32'h1084);
        chk("R2 strobes low", 32'({redirect_o, s_we_o, m_we_o, dbg_we_o, resv_clr_o, priv_flush_o}), 32'd0);

        // R1 again: reset after activity
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pc after reset", pc_o, RST_PC);
        chk("R1 status after reset", 32'(status_o), 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule